// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a small synchronous up-counter, four bits wide by default. It has an asynchronous active-low clear and a synchronous active-low parallel load. Two count enables must both be high for the counter to advance. The first, the parallel enable, only qualifies counting. The second, the trickle enable, also gates a combinational terminal-count flag that is high in the all-ones state.

Several copies can be chained into a wider counter. All stages share the clock, the clear, the load and the parallel enable. Each stage's terminal-count output drives the trickle enable of the stage above it. The chain then behaves as one wide binary counter, with a carry that is ready ahead of the clock edge that needs it.

Top module: `casc_counter`

## Requirements
- R1: When the clear is released without a clock edge, `cnt` stays at zero. It also stays at zero through every following edge that neither loads nor counts.
- R2: While `clr_n` is low, `cnt` is zero at once, with no clock edge needed.
- R3: On a rising edge with `ld_n` low and `clr_n` high, `cnt` takes `din`. The levels of `en_par` and `en_trk` do not matter.
- R4: On a rising edge with `ld_n`, `en_par` and `en_trk` all high, `cnt` increases by one.
- R5: On a rising edge with `ld_n` high and either enable low, `cnt` keeps its value.
- R6: `term` is 1 exactly when `en_trk` is 1 and `cnt` is all ones. It follows `en_trk` with no clock edge.
- R7: A counting edge in the all-ones state wraps `cnt` to all zeros.
- R8: Two stages with the upper stage's `en_trk` driven by the lower stage's `term` count as one 8-bit binary counter. The lower stage is the low nibble. The upper stage and the shared enable are as described above.
- R9: A low `clr_n` overrides a low `ld_n` and any rising edges, holding `cnt` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates `term` |
| din | input | WIDTH | Parallel load data |
| cnt | output | WIDTH | Counter state |
| term | output | 1 | Terminal count: all ones while `en_trk` is high |

## Verification
Two pairs of functions can meet in the same cycle: load with counting, and clear with load.

The bench drives `ld_n` low with both enables high and expects the loaded value rather than an increment. It also drops `clr_n` while `ld_n` is low and rising edges keep arriving, and expects zero on every edge.

The wrap edge is another meeting point. The terminal-count flag is high in the cycle that `cnt` rolls over, and in the chained pair that same edge carries into the upper stage. The bench judges this against a full 8-bit reference count.

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cnt,
  output logic             term
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] STEP     = {{(WIDTH-1){1'b0}}, 1'b1};

  logic advance;
  logic at_top;

  assign advance = ld_n & en_par & en_trk;
  assign at_top  = (cnt == ALL_ONES);
  assign term    = en_trk & at_top;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      cnt <= '0;
    else if (!ld_n)
      cnt <= din;
    else if (advance)
      cnt <= cnt + STEP;
  end
endmodule

module casc_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             ld_n,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] cnt,
  input logic             term
);
  localparam logic [WIDTH-1:0] STEP = {{(WIDTH-1){1'b0}}, 1'b1};

  always @(posedge clk) begin
    if (!clr_n) begin
      p_clear_zero_r2: assert (cnt == '0);
    end
  end

  p_load_wins_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> cnt == $past(din));

  p_count_up_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_par && en_trk) |=> cnt == $past(cnt) + STEP);

  p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_par && en_trk)) |=> $stable(cnt));

  p_term_gated_r6: assert property (@(posedge clk) disable iff (!clr_n)
    term |-> en_trk);

  p_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (term && en_par && ld_n) |=> cnt == '0);
endmodule

bind casc_counter casc_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/casc_counter_bench.sv
module casc_counter_bench;
  typedef struct {
    logic [3:0] val;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       ld_n = 1'b1;
  logic       en_par = 1'b0;
  logic       en_trk = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] cnt;
  logic       term;

  logic       c_ld_n = 1'b1;
  logic       c_en = 1'b0;
  logic [7:0] c_din = '0;
  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_term, hi_term;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] model = '0;
  exp_t q_exp[$];

  always #4 clk = ~clk;

  casc_counter #(.WIDTH(4)) u_casc_counter (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_par(en_par), .en_trk(en_trk),
    .din(din), .cnt(cnt), .term(term));

  casc_counter #(.WIDTH(4)) u_lo (
    .clk(clk), .clr_n(clr_n), .ld_n(c_ld_n), .en_par(c_en), .en_trk(1'b1),
    .din(c_din[3:0]), .cnt(lo_cnt), .term(lo_term));

  casc_counter #(.WIDTH(4)) u_hi (
    .clk(clk), .clr_n(clr_n), .ld_n(c_ld_n), .en_par(c_en), .en_trk(lo_term),
    .din(c_din[7:4]), .cnt(hi_cnt), .term(hi_term));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: one call per cycle, inputs set at the falling edge
  task automatic step(input logic l, input logic p, input logic t,
                      input logic [3:0] d, input string req);
    exp_t e;
    @(negedge clk);
    ld_n = l; en_par = p; en_trk = t; din = d;
    #1;
    check("R6", {7'd0, term}, {7'd0, t && (model == 4'hF)});
    if (!clr_n) model = '0;
    else if (!l) model = d;
    else if (p && t) model = model + 4'd1;
    e.val = model;
    e.req = req;
    q_exp.push_back(e);
  endtask

  // monitor: compares just after each rising edge
  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      exp_t e;
      e = q_exp.pop_front();
      check(e.req, {4'd0, cnt}, {4'd0, e.val});
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] ref8;
    #3;
    check("R2", {4'd0, cnt}, 8'd0);
    check("R6", {7'd0, term}, 8'd0);
    @(negedge clk);
    clr_n = 1'b1;
    #1;
    check("R1", {4'd0, cnt}, 8'd0);
    step(1, 0, 0, 4'hA, "R1");
    step(1, 1, 0, 4'h3, "R1");
    step(0, 0, 0, 4'h5, "R3");
    step(1, 0, 1, 4'h0, "R5");
    step(0, 1, 1, 4'h9, "R3");
    for (int i = 0; i < 6; i++) step(1, 1, 1, 4'h0, "R4");
    step(1, 1, 1, 4'h0, "R7");
    step(0, 1, 0, 4'hF, "R3");
    step(1, 1, 0, 4'h0, "R5");
    step(1, 0, 1, 4'h0, "R5");
    @(negedge clk);
    en_trk = 1'b0;
    #1;
    check("R6", {7'd0, term}, 8'd0);
    en_trk = 1'b1;
    #1;
    check("R6", {7'd0, term}, 8'd1);
    step(1, 1, 1, 4'h0, "R7");
    step(1, 1, 1, 4'h0, "R4");
    // clear against load and clock edges
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    check("R2", {4'd0, cnt}, 8'd0);
    model = '0;
    step(0, 1, 1, 4'hC, "R9");
    step(0, 0, 0, 4'h7, "R9");
    @(negedge clk);
    ld_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
    clr_n = 1'b1;
    step(1, 0, 1, 4'h0, "R1");
    step(1, 1, 1, 4'h0, "R4");
    // chained pair as an 8-bit counter
    @(negedge clk);
    c_ld_n = 1'b0; c_din = 8'hEC; c_en = 1'b0;
    @(posedge clk);
    ref8 = 8'hEC;
    @(negedge clk);
    check("R8", {hi_cnt, lo_cnt}, ref8);
    c_ld_n = 1'b1;
    for (int i = 0; i < 300; i++) begin
      c_en = (i % 7) != 3;
      @(posedge clk);
      if (c_en) ref8 = ref8 + 8'd1;
      @(negedge clk);
      check("R8", {hi_cnt, lo_cnt}, ref8);
      check("R8", {7'd0, hi_term}, {7'd0, lo_term && (hi_cnt == 4'hF)});
    end
    @(negedge clk);
    finish_run();
  end
endmodule